// File: doc/BRIEF.md
# Shifter and ALU Function Unit

This is the combinational arithmetic stage of a small 32-bit datapath. Operand A goes through a one-position shifter. In parallel, A and B go through an eight-function ALU with carry-in. A single carry output feeds the processor's carry flag.

A second, separate section turns the controller's execute-phase lines and its one-hot instruction lines into the shifter code, the ALU code and the carry-in. The controller normally routes these decoded codes back into the function inputs. The two halves are exposed separately so that every function code can also be driven directly. The unit holds no state.

Top module: `alu_shift_unit`

## Requirements
- R1: Shifter code `shf_fn_i` gives `shf_o` as follows. 00 passes A. 01 shifts A left by one and fills with zero. 10 shifts A right by one and copies bit 31. 11 rotates A right by one, so bit 0 enters bit 31.
- R2: ALU code `alu_fn_i` gives `alu_o` as follows: 000 zero, 001 B−A, 010 A−B, 011 A+B, 100 A xor B, 101 A or B, 110 A and B, 111 all ones.
- R3: `cin_i` is added to the result of codes 001, 010 and 011. It has no effect on the result or carry of any other code.
- R4: With shifter code 00, `carry_o` depends on the ALU code:
  - For 011 it is the carry out of bit 31.
  - For 001 and 010 it is 1 when there is no borrow, that is when minuend + `cin_i` ≥ subtrahend.
  - For all other codes it is 0.
- R5: With a nonzero shifter code, `carry_o` is the bit shifted out, whatever the ALU code: A[31] for code 01 and A[0] for codes 10 and 11.
- R6: The one-hot lines `op_i` use these bit positions: 0 shift-left, 1 arithmetic shift-right, 2 rotate-right, 3 add, 4 subtract, 5 and, 6 or, 7 complement, 8 decrement, 9 increment, 10 compare. `shf_fn_o` is 01 for shift-left, 10 for shift-right, 11 for rotate and 00 otherwise, in any phase.
- R7: During phase-3 (`ph3_i`), `alu_fn_o` takes these values:
  - 011 for add, decrement and increment;
  - 010 for subtract and compare;
  - 110 for and;
  - 101 for or;
  - 100 for complement;
  - 000 otherwise.
- R8: During phase-2 (`ph2_i`), `alu_fn_o` is 111 for complement and decrement and 000 otherwise. With neither phase line high it is 000.
- R9: `cin_o` is 1 only for increment during phase-3, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| shf_fn_i | input | 2 | Shifter function code |
| alu_fn_i | input | 3 | ALU function code |
| cin_i | input | 1 | Adder carry-in |
| shf_o | output | 32 | Shifted A |
| alu_o | output | 32 | ALU result |
| carry_o | output | 1 | Carry to the flag register |
| ph2_i | input | 1 | Execute phase 2 active |
| ph3_i | input | 1 | Execute phase 3 active |
| op_i | input | 11 | One-hot decoded instruction lines |
| shf_fn_o | output | 2 | Decoded shifter code |
| alu_fn_o | output | 3 | Decoded ALU code |
| cin_o | output | 1 | Decoded carry-in |

## Verification
The shifter and the ALU act in the same evaluation and compete for the one carry output. The bench drives every shifter code together with every ALU code and both carry-in values on a set of operand pairs. Some pairs are picked so that the add carry and the shifted-out bit disagree, for example A=0x7FFFFFFF with B=0x80000001 under shift-left and add. A reference model in the bench decides which source must win in each case. The outcome is judged on `carry_o` alongside both data results.

// File: rtl/asu_pkg.sv
`timescale 1ns/1ps
package asu_pkg;
  localparam int NUM_OPS = 11;

  typedef enum logic [1:0] {
    SHF_PASS = 2'b00,
    SHF_SHL  = 2'b01,
    SHF_SAR  = 2'b10,
    SHF_ROR  = 2'b11
  } shf_fn_e;

  typedef enum logic [2:0] {
    ALU_ZERO = 3'b000,
    ALU_RSUB = 3'b001,
    ALU_SUB  = 3'b010,
    ALU_ADD  = 3'b011,
    ALU_XOR  = 3'b100,
    ALU_OR   = 3'b101,
    ALU_AND  = 3'b110,
    ALU_ONES = 3'b111
  } alu_fn_e;

  // one-hot instruction line positions
  localparam int OP_SHL = 0;
  localparam int OP_SAR = 1;
  localparam int OP_ROR = 2;
  localparam int OP_ADD = 3;
  localparam int OP_SUB = 4;
  localparam int OP_AND = 5;
  localparam int OP_OR  = 6;
  localparam int OP_CPL = 7;
  localparam int OP_DEC = 8;
  localparam int OP_INC = 9;
  localparam int OP_CMP = 10;
endpackage

// File: rtl/asu_decode.sv
`timescale 1ns/1ps
module asu_decode
  import asu_pkg::*;
(
  input  logic               ph2_i,
  input  logic               ph3_i,
  input  logic [NUM_OPS-1:0] op_i,
  output logic [1:0]         shf_fn_o,
  output logic [2:0]         alu_fn_o,
  output logic               cin_o
);
  logic p2_grp;
  logic p3_arith;

  always_comb begin
    // phase-2 preload of all ones for complement / decrement
    p2_grp   = ph2_i & (op_i[OP_CPL] | op_i[OP_DEC]);
    p3_arith = op_i[OP_DEC] | op_i[OP_INC] | op_i[OP_ADD];

    shf_fn_o[1] = op_i[OP_SAR] | op_i[OP_ROR];
    shf_fn_o[0] = op_i[OP_SHL] | op_i[OP_ROR];

    alu_fn_o[2] = (ph3_i & (op_i[OP_CPL] | op_i[OP_OR] | op_i[OP_AND])) | p2_grp;
    alu_fn_o[1] = (ph3_i & (op_i[OP_SUB] | op_i[OP_CMP] | p3_arith | op_i[OP_AND]))
                | p2_grp;
    alu_fn_o[0] = (ph3_i & (p3_arith | op_i[OP_OR])) | p2_grp;

    cin_o = ph3_i & op_i[OP_INC];
  end
endmodule

// File: rtl/asu_shifter.sv
`timescale 1ns/1ps
module asu_shifter
  import asu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [1:0]   fn_i,
  output logic [W-1:0] y_o,
  output logic         out_bit_o
);
  always_comb begin
    unique case (fn_i)
      SHF_SHL: begin
        y_o       = {a_i[W-2:0], 1'b0};
        out_bit_o = a_i[W-1];
      end
      SHF_SAR: begin
        y_o       = {a_i[W-1], a_i[W-1:1]};
        out_bit_o = a_i[0];
      end
      SHF_ROR: begin
        y_o       = {a_i[0], a_i[W-1:1]};
        out_bit_o = a_i[0];
      end
      default: begin
        y_o       = a_i;
        out_bit_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/asu_alu.sv
`timescale 1ns/1ps
module asu_alu
  import asu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   fn_i,
  input  logic         cin_i,
  output logic [W-1:0] y_o,
  output logic         carry_o
);
  // two spare bits: subtract with carry-in can reach 2^(W+1)
  localparam int EXT = W + 2;

  logic [W-1:0]   op_x;
  logic [W-1:0]   op_y;
  logic           is_sub;
  logic [EXT-1:0] sum;

  always_comb begin
    unique case (fn_i)
      ALU_RSUB: begin op_x = b_i; op_y = ~a_i; is_sub = 1'b1; end
      ALU_SUB:  begin op_x = a_i; op_y = ~b_i; is_sub = 1'b1; end
      default:  begin op_x = a_i; op_y = b_i;  is_sub = 1'b0; end
    endcase
    sum = {2'b00, op_x} + {2'b00, op_y} + EXT'(is_sub) + EXT'(cin_i);
  end

  always_comb begin
    carry_o = 1'b0;
    unique case (fn_i)
      ALU_ZERO: y_o = '0;
      ALU_RSUB, ALU_SUB, ALU_ADD: begin
        y_o     = sum[W-1:0];
        carry_o = |sum[EXT-1:W];
      end
      ALU_XOR:  y_o = a_i ^ b_i;
      ALU_OR:   y_o = a_i | b_i;
      ALU_AND:  y_o = a_i & b_i;
      default:  y_o = '1;
    endcase
  end
endmodule

// File: rtl/alu_shift_unit.sv
`timescale 1ns/1ps
module alu_shift_unit
  import asu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]       a_i,
  input  logic [W-1:0]       b_i,
  input  logic [1:0]         shf_fn_i,
  input  logic [2:0]         alu_fn_i,
  input  logic               cin_i,
  output logic [W-1:0]       shf_o,
  output logic [W-1:0]       alu_o,
  output logic               carry_o,
  input  logic               ph2_i,
  input  logic               ph3_i,
  input  logic [NUM_OPS-1:0] op_i,
  output logic [1:0]         shf_fn_o,
  output logic [2:0]         alu_fn_o,
  output logic               cin_o
);
  logic shf_bit;
  logic alu_carry;

  asu_decode u_decode (
    .ph2_i    (ph2_i),
    .ph3_i    (ph3_i),
    .op_i     (op_i),
    .shf_fn_o (shf_fn_o),
    .alu_fn_o (alu_fn_o),
    .cin_o    (cin_o)
  );

  asu_shifter #(.W(W)) u_shifter (
    .a_i       (a_i),
    .fn_i      (shf_fn_i),
    .y_o       (shf_o),
    .out_bit_o (shf_bit)
  );

  asu_alu #(.W(W)) u_alu (
    .a_i     (a_i),
    .b_i     (b_i),
    .fn_i    (alu_fn_i),
    .cin_i   (cin_i),
    .y_o     (alu_o),
    .carry_o (alu_carry)
  );

  // an active shift owns the flag
  assign carry_o = (shf_fn_i != SHF_PASS) ? shf_bit : alu_carry;
endmodule

// File: rtl/asu_checker.sv
`timescale 1ns/1ps
module asu_checker
  import asu_pkg::*;
#(
  parameter int W = 32
) (
  input logic [W-1:0]       a_i,
  input logic [W-1:0]       b_i,
  input logic [1:0]         shf_fn_i,
  input logic [2:0]         alu_fn_i,
  input logic               cin_i,
  input logic [W-1:0]       shf_o,
  input logic [W-1:0]       alu_o,
  input logic               carry_o,
  input logic               ph2_i,
  input logic               ph3_i,
  input logic [NUM_OPS-1:0] op_i,
  input logic [1:0]         shf_fn_o,
  input logic [2:0]         alu_fn_o,
  input logic               cin_o
);
  always_comb begin
    if (!$isunknown({a_i, b_i, shf_fn_i, alu_fn_i, cin_i})) begin
      a_r1_pass: assert ((shf_fn_i != SHF_PASS) || (shf_o == a_i))
        else $error("R1 pass-through mismatch");
      a_r1_ror_ring: assert ((shf_fn_i != SHF_ROR) || ({shf_o[W-2:0], shf_o[W-1]} == a_i))
        else $error("R1 rotate mismatch");
      a_r2_ones: assert ((alu_fn_i != ALU_ONES) || (&alu_o))
        else $error("R2 all-ones mismatch");
      a_r4_no_borrow: assert (!((alu_fn_i == ALU_SUB) && (shf_fn_i == SHF_PASS) && !cin_i)
                              || (carry_o == (a_i >= b_i)))
        else $error("R4 borrow flag mismatch");
      a_r5_shl_carry: assert ((shf_fn_i != SHF_SHL) || (carry_o == a_i[W-1]))
        else $error("R5 shift-left carry mismatch");
    end
    if (!$isunknown({ph2_i, ph3_i, op_i})) begin
      a_r8_idle: assert (ph2_i || ph3_i || (alu_fn_o == ALU_ZERO))
        else $error("R8 idle code nonzero");
      a_r9_cin: assert (!cin_o || (ph3_i && op_i[OP_INC]))
        else $error("R9 stray carry-in");
    end
  end
endmodule

bind alu_shift_unit asu_checker #(.W(W)) u_asu_checker (.*);

// File: tb/alu_shift_unit_bench.sv
`timescale 1ns/1ps
module alu_shift_unit_bench;
  import asu_pkg::*;
  localparam int W = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0]       a, b, shf_y, alu_y;
  logic [1:0]         shf_fn, shf_fn_d;
  logic [2:0]         alu_fn, alu_fn_d;
  logic               cin, carry, cin_d, ph2, ph3;
  logic [NUM_OPS-1:0] op;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  alu_shift_unit #(.W(W)) u_alu_shift_unit (
    .a_i(a), .b_i(b), .shf_fn_i(shf_fn), .alu_fn_i(alu_fn), .cin_i(cin),
    .shf_o(shf_y), .alu_o(alu_y), .carry_o(carry),
    .ph2_i(ph2), .ph3_i(ph3), .op_i(op),
    .shf_fn_o(shf_fn_d), .alu_fn_o(alu_fn_d), .cin_o(cin_d)
  );

  // operand pairs: {A, B}
  localparam logic [63:0] VEC [12] = '{
    {32'h0000_0000, 32'h0000_0000}, {32'hFFFF_FFFF, 32'h0000_0001},
    {32'h8000_0000, 32'h8000_0000}, {32'h7FFF_FFFF, 32'h8000_0001},
    {32'h0000_0005, 32'h0000_0007}, {32'h0000_0007, 32'h0000_0005},
    {32'h1234_5678, 32'h1234_5678}, {32'hDEAD_BEEF, 32'h0F0F_F0F0},
    {32'h0000_0001, 32'hFFFF_FFFF}, {32'hAAAA_AAAA, 32'h5555_5555},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF}, {32'h8000_0001, 32'h0000_0002}
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] ref_shift(logic [31:0] x, logic [1:0] fn);
    case (fn)
      2'b01:   return {x[31], x << 1};
      2'b10:   return {x[0], 32'($signed(x) >>> 1)};
      2'b11:   return {x[0], x[0], x[31:1]};
      default: return {1'b0, x};
    endcase
  endfunction

  function automatic logic [32:0] ref_alu(logic [31:0] x, logic [31:0] y, logic [2:0] fn,
                                          logic ci);
    longint lx = longint'(x);
    longint ly = longint'(y);
    longint lc = longint'(ci);
    longint t;
    case (fn)
      3'b001: begin t = ly - lx + lc; return {ly + lc >= lx, t[31:0]}; end
      3'b010: begin t = lx - ly + lc; return {lx + lc >= ly, t[31:0]}; end
      3'b011: begin t = lx + ly + lc; return {t[32], t[31:0]}; end
      3'b100: return {1'b0, x ^ y};
      3'b101: return {1'b0, x | y};
      3'b110: return {1'b0, x & y};
      3'b111: return {1'b0, 32'hFFFF_FFFF};
      default: return 33'd0;
    endcase
  endfunction

  // expected {shf, alu, cin} for a single op line and phase, per R6..R9
  function automatic logic [5:0] ref_dec(int idx, logic p2, logic p3);
    logic [1:0] s = 2'b00;
    logic [2:0] f = 3'b000;
    if (idx == OP_SHL) s = 2'b01;
    if (idx == OP_SAR) s = 2'b10;
    if (idx == OP_ROR) s = 2'b11;
    if (p3) begin
      if (idx == OP_ADD || idx == OP_DEC || idx == OP_INC) f = 3'b011;
      if (idx == OP_SUB || idx == OP_CMP) f = 3'b010;
      if (idx == OP_AND) f = 3'b110;
      if (idx == OP_OR)  f = 3'b101;
      if (idx == OP_CPL) f = 3'b100;
    end else if (p2) begin
      if (idx == OP_CPL || idx == OP_DEC) f = 3'b111;
    end
    return {s, f, p3 && idx == OP_INC};
  endfunction

  task automatic drive(logic [31:0] x, logic [31:0] y, logic [1:0] s, logic [2:0] f,
                       logic ci);
    @(negedge clk);
    a = x; b = y; shf_fn = s; alu_fn = f; cin = ci;
    #1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    a = '0; b = '0; shf_fn = '0; alu_fn = '0; cin = 1'b0;
    ph2 = 1'b0; ph3 = 1'b0; op = '0;
    @(negedge clk); #1;
    // idle state: no phase, no op
    chk("R8 idle alu code", 64'(alu_fn_d), 64'd0);
    chk("R9 idle carry-in", 64'(cin_d), 64'd0);
    chk("R1 idle pass", 64'(shf_y), 64'd0);

    // table walk: all codes, both carry-ins (R1..R5)
    for (int v = 0; v < 12; v++) begin
      for (int s = 0; s < 4; s++) begin
        for (int f = 0; f < 8; f++) begin
          for (int c = 0; c < 2; c++) begin
            logic [32:0] es, ea;
            drive(VEC[v][63:32], VEC[v][31:0], 2'(s), 3'(f), c[0]);
            es = ref_shift(a, shf_fn);
            ea = ref_alu(a, b, alu_fn, cin);
            chk("R1 shifter", 64'(shf_y), 64'(es[31:0]));
            chk("R2 R3 alu result", 64'(alu_y), 64'(ea[31:0]));
            if (s == 0) chk("R4 alu carry", 64'(carry), 64'(ea[32]));
            else        chk("R5 shift carry", 64'(carry), 64'(es[32]));
          end
        end
      end
    end

    // directed corners
    drive(32'hFFFF_FFFF, 32'h1, 2'b00, 3'b011, 1'b0);
    chk("R4 add wrap result", 64'(alu_y), 64'd0);
    chk("R4 add wrap carry", 64'(carry), 64'd1);
    drive(32'h5, 32'h7, 2'b00, 3'b010, 1'b0);
    chk("R2 5-7", 64'(alu_y), 64'hFFFF_FFFE);
    chk("R4 borrow", 64'(carry), 64'd0);
    drive(32'h5, 32'h7, 2'b00, 3'b001, 1'b1);
    chk("R3 7-5+1", 64'(alu_y), 64'd3);
    drive(32'h5, 32'h7, 2'b00, 3'b100, 1'b1);
    chk("R3 cin ignored by xor", 64'(alu_y), 64'd2);
    chk("R3 cin no carry on xor", 64'(carry), 64'd0);
    drive(32'h8000_0000, 32'h0, 2'b10, 3'b000, 1'b0);
    chk("R1 sar sign", 64'(shf_y), 64'hC000_0000);
    drive(32'h1, 32'h0, 2'b11, 3'b000, 1'b0);
    chk("R1 ror wrap", 64'(shf_y), 64'h8000_0000);
    chk("R5 ror carry", 64'(carry), 64'd1);
    // shift-left and overflowing add together: shift bit wins
    drive(32'h7FFF_FFFF, 32'h8000_0001, 2'b01, 3'b011, 1'b0);
    chk("R5 shl vs add carry", 64'(carry), 64'd0);
    chk("R5 add result alongside", 64'(alu_y), 64'd0);

    // decode sweep (R6..R9)
    for (int i = 0; i < NUM_OPS; i++) begin
      for (int p = 0; p < 3; p++) begin
        logic [5:0] e;
        @(negedge clk);
        op = '0; op[i] = 1'b1; ph2 = (p == 1); ph3 = (p == 2);
        #1;
        e = ref_dec(i, ph2, ph3);
        chk("R6 shift decode", 64'(shf_fn_d), 64'(e[5:4]));
        chk(p == 2 ? "R7 phase3 decode" : "R8 phase2/idle decode", 64'(alu_fn_d), 64'(e[3:1]));
        chk("R9 carry-in decode", 64'(cin_d), 64'(e[0]));
      end
    end
    finish_run();
  end
endmodule